// File: doc/BRIEF.md
# Return-to-Zero Serial Word Receiver

The block turns a two-line return-to-zero serial stream into 32-bit words. Each line signal gives a digital line state. A pulse on the positive line carries a one, a pulse on the negative line carries a zero, and every pulse returns to null (both low) before the next one. A rising edge of "either line high" marks a bit, and the bits are shifted into an input register. A word ends only when the line has stayed at null for a set number of gap-clock periods. At that point the collected bits are transferred to the output with a one-cycle strobe and a bit-count error flag. When parity checking is on, the top bit of the word is replaced by a parity-error indicator.

A pair of test inputs can take the place of the line inputs. While either test input is high, the test inputs set the line state and the line inputs are ignored. All asynchronous inputs pass through multi-flop synchronisers into the system clock domain. Edges of the gap clock are detected in that domain. After reset, nothing is accepted until the line has been idle for one full gap, so a word that was cut off by reset never reaches the output.

Top module: `rz_word_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `word_vld`, `word_data` and `word_err` are all zero.
- R2: A pulse on the positive line is a one and a pulse on the negative line is a zero. Each new bit enters at bit 31 and moves the earlier bits down by one position, so the first of 32 bits ends at bit 0. The input register is cleared after every gap, and for other bit counts the output holds the last bits shifted in.
- R3: A word ends when the line stays at null for 16 rising edges of the gap clock (`GAP_CYCLES`). A null stretch shorter than 13 gap-clock periods inside a word does not split it.
- R4: Every transferred word gives exactly one `word_vld` pulse of one cycle. `word_data` and `word_err` hold their values until the next pulse.
- R5: On a transfer, `word_err` is 1 when the bit count since the previous gap is not exactly 32. This includes counts above 32, because the counter saturates at 33.
- R6: `word_err` returns to 0 on the next transfer of exactly 32 bits, and `word_err` changes only on `word_vld` cycles or on reset.
- R7: With `par_en` high, bit 31 of `word_data` is 1 when the 32 received bits hold an even number of ones, and 0 otherwise. With `par_en` low, bit 31 is the received bit unchanged.
- R8: After reset, bits are ignored and no word is produced until the first gap. That first gap only arms the receiver.
- R9: While either test input is high, the test inputs set the line state and the line inputs have no effect. Only `test_pos` high means a one, only `test_neg` high means a zero, and both high means null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pos | input | 1 | Positive line state (one), asynchronous |
| line_neg | input | 1 | Negative line state (zero), asynchronous |
| test_pos | input | 1 | Test substitute for the positive line |
| test_neg | input | 1 | Test substitute for the negative line |
| gap_clk | input | 1 | Gap-timing clock, asynchronous, 1/8 of `clk` or slower |
| par_en | input | 1 | Odd parity check enable |
| word_vld | output | 1 | One-cycle transfer strobe |
| word_data | output | 32 | Last transferred word |
| word_err | output | 1 | Bit-count error of the last transferred word |

## Verification
The bench builds the receiver with its defaults: 32-bit words, a 16-period gap and two synchroniser stages. It drives the gap clock at one eighth of the system clock, so a full gap lasts about 128 system cycles. This makes it possible to show both that the strobe does not come in the first 96 cycles of idle and that a 100-cycle pause inside a word does not split it. With the default word size, a 31-bit word, a 33-bit word and a 40-bit word fall on both sides of the count boundary and beyond the counter's saturation point.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;

    // State of the two lines: pos high carries a one, neg high a zero
    typedef struct packed {
        logic pos;
        logic neg;
    } line_t;

    typedef enum logic {
        ST_WAIT_GAP = 1'b0,
        ST_ARMED    = 1'b1
    } arm_e;

    // Test inputs take over when either one is high; both high means null
    function automatic line_t pick_source(input line_t rx, input line_t tst);
        line_t r;
        if (tst.pos || tst.neg) begin
            r.pos = tst.pos & ~tst.neg;
            r.neg = tst.neg & ~tst.pos;
        end else begin
            r = rx;
        end
        return r;
    endfunction

endpackage

// File: rtl/rzrx_sync.sv
module rzrx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rzrx_slicer.sv
module rzrx_slicer
    import rzrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t ln,
    output logic  active,
    output logic  bit_evt,
    output logic  bit_val
);
    logic active_q;

    assign active  = ln.pos | ln.neg;
    assign bit_evt = active & ~active_q;
    assign bit_val = ln.pos;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    // R2
    bit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bit_evt |=> !bit_evt);
endmodule

// File: rtl/rzrx_gap_timer.sv
module rzrx_gap_timer #(
    parameter int GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic gclk_s,
    input  logic active,
    output logic gap
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [GAP_W-1:0] LAST = GAP_W'(GAP_CYCLES - 1);
    localparam logic [GAP_W-1:0] FULL = GAP_W'(GAP_CYCLES);

    logic             gclk_q;
    logic             tick;
    logic [GAP_W-1:0] idle_cnt;

    assign tick = gclk_s & ~gclk_q;
    assign gap  = ~active & tick & (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            gclk_q   <= 1'b0;
            idle_cnt <= '0;
        end else begin
            gclk_q <= gclk_s;
            if (active)                     idle_cnt <= '0;
            else if (tick && idle_cnt != FULL) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R3
    gap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        gap |=> !gap);
endmodule

// File: rtl/rz_word_rx.sv
module rz_word_rx
    import rzrx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int GAP_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_pos,
    input  logic                 line_neg,
    input  logic                 test_pos,
    input  logic                 test_neg,
    input  logic                 gap_clk,
    input  logic                 par_en,
    output logic                 word_vld,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_err
);
    localparam int CNT_W = $clog2(WORD_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_BITS + 1);
    localparam int N_SYNC = 6;

    logic [N_SYNC-1:0] raw_in, syn_in;
    line_t             rx_s, tst_s, src;
    logic              gclk_s, par_s;
    logic              active, bit_evt, bit_val, gap;

    arm_e                 arm;
    logic [WORD_BITS-1:0] shreg;
    logic [WORD_BITS-1:0] shaped;
    logic [CNT_W-1:0]     bit_cnt;

    assign raw_in = {par_en, gap_clk, test_neg, test_pos, line_neg, line_pos};

    rzrx_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
    );

    assign rx_s   = '{pos: syn_in[0], neg: syn_in[1]};
    assign tst_s  = '{pos: syn_in[2], neg: syn_in[3]};
    assign gclk_s = syn_in[4];
    assign par_s  = syn_in[5];
    assign src    = pick_source(rx_s, tst_s);

    rzrx_slicer slicer_i (
        .clk(clk), .rst(rst), .ln(src),
        .active(active), .bit_evt(bit_evt), .bit_val(bit_val)
    );

    rzrx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
        .clk(clk), .rst(rst), .gclk_s(gclk_s), .active(active), .gap(gap)
    );

    // Top bit becomes the parity-error indicator when checking is enabled
    always_comb begin
        shaped = shreg;
        if (par_s) shaped[WORD_BITS-1] = ~(^shreg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm       <= ST_WAIT_GAP;
            shreg     <= '0;
            bit_cnt   <= '0;
            word_vld  <= 1'b0;
            word_data <= '0;
            word_err  <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (gap) begin
                if (arm == ST_ARMED) begin
                    word_vld  <= 1'b1;
                    word_data <= shaped;
                    word_err  <= (bit_cnt != CNT_FULL);
                end
                arm     <= ST_ARMED;
                shreg   <= '0;
                bit_cnt <= '0;
            end else if (bit_evt && arm == ST_ARMED) begin
                shreg <= {bit_val, shreg[WORD_BITS-1:1]};
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R4
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld |-> $stable(word_data));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld |-> $stable(word_err));

    // R8
    armed_first_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(arm == ST_ARMED));
endmodule

// File: tb/rz_word_rx_tb_top.sv
module rz_word_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_pos = 1'b0, line_neg = 1'b0;
    logic        test_pos = 1'b0, test_neg = 1'b0;
    logic        gap_clk = 1'b0;
    logic        par_en = 1'b0;
    logic        word_vld;
    logic [31:0] word_data;
    logic        word_err;

    int checks = 0;
    int errors = 0;
    int n_strobe = 0;
    int n_double = 0;
    logic vld_d = 1'b0;
    logic [31:0] prev_data;
    logic        prev_err;
    logic        got;

    always #4 clk = ~clk;
    initial forever begin
        repeat (4) @(posedge clk);
        gap_clk = ~gap_clk;
    end

    rz_word_rx dut_i (
        .clk(clk), .rst(rst), .line_pos(line_pos), .line_neg(line_neg),
        .test_pos(test_pos), .test_neg(test_neg), .gap_clk(gap_clk),
        .par_en(par_en), .word_vld(word_vld), .word_data(word_data),
        .word_err(word_err)
    );

    always @(posedge clk) begin
        if (word_vld) n_strobe <= n_strobe + 1;
        if (word_vld && vld_d) n_double <= n_double + 1;
        vld_d <= word_vld;
    end

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] nbits;
        logic        par;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'hA5A5_0F0F, 32'd32, 1'b0},
        '{32'h0000_0001, 32'd32, 1'b1},
        '{32'h8000_0003, 32'd32, 1'b1},
        '{32'h0000_0003, 32'd32, 1'b1},
        '{32'h1234_5678, 32'd31, 1'b0},
        '{32'hFFFF_FFFF, 32'd32, 1'b0},
        '{32'h0F0F_0F0F, 32'd33, 1'b0},
        '{32'hC3C3_C3C3, 32'd40, 1'b1},
        '{32'hDEAD_BEEF, 32'd32, 1'b0}
    };

    function automatic logic [31:0] model(input logic [31:0] d, input int n, input logic p);
        logic [31:0] sr = '0;
        for (int i = 0; i < n; i++) sr = {d[i % 32], sr[31:1]};
        if (p) sr[31] = ~(^sr);
        return sr;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic via_test);
        @(negedge clk);
        if (via_test) begin test_pos = b; test_neg = ~b; end
        else          begin line_pos = b; line_neg = ~b; end
        repeat (4) @(negedge clk);
        if (via_test) begin test_pos = 1'b0; test_neg = 1'b0; end
        else          begin line_pos = 1'b0; line_neg = 1'b0; end
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] d, input int n, input logic via_test);
        for (int i = 0; i < n; i++) send_bit(d[i % 32], via_test);
    endtask

    task automatic wait_strobe(input int limit, output logic seen);
        int start = n_strobe;
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (n_strobe != start) seen = 1'b1;
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        // R1 reset values
        check("R1 vld in reset", {31'd0, word_vld}, 32'd0);
        check("R1 data in reset", word_data, 32'd0);
        check("R1 err in reset", {31'd0, word_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after reset", {31'd0, word_vld}, 32'd0);

        // R8 first idle gap only arms
        base = n_strobe;
        repeat (300) @(negedge clk);
        check("R8 no word at first gap", n_strobe - base, 0);

        // R8 partial word cut by reset is never delivered
        send_word(32'hFFFF_FFFF, 10, 1'b0);
        @(negedge clk); rst = 1'b1;
        repeat (5) @(negedge clk); rst = 1'b0;
        base = n_strobe;
        send_word(32'hFFFF_FFFF, 22, 1'b0);
        repeat (600) @(negedge clk);
        check("R8 tail after reset dropped", n_strobe - base, 0);
        check("R8 err after tail", {31'd0, word_err}, 32'd0);

        // Vector table: R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk); par_en = VECS[v].par;
            repeat (10) @(negedge clk);
            send_word(VECS[v].data, int'(VECS[v].nbits), 1'b0);
            wait_strobe(600, got);
            check("R4 strobe seen", {31'd0, got}, 32'd1);
            check("R2/R7 word", word_data,
                  model(VECS[v].data, int'(VECS[v].nbits), VECS[v].par));
            check("R5/R6 count error", {31'd0, word_err},
                  {31'd0, VECS[v].nbits != 32});
        end
        @(negedge clk); par_en = 1'b0;

        // R4 hold between strobes and single-cycle pulse
        prev_data = word_data; prev_err = word_err;
        repeat (50) @(negedge clk);
        check("R4 data held", word_data, prev_data);
        check("R6 err held", {31'd0, word_err}, {31'd0, prev_err});
        check("R4 single-cycle strobes", n_double, 0);

        // R3 error word, then gap timing and mid-word pause
        send_word(32'h0000_00FF, 20, 1'b0);
        wait_strobe(600, got);
        check("R5 short word error", {31'd0, word_err}, 32'd1);
        base = n_strobe;
        send_word(32'h5A5A_3C3C, 16, 1'b0);
        repeat (100) @(negedge clk);
        send_word(32'h5A5A_3C3C >> 16, 16, 1'b0);
        repeat (96) @(negedge clk);
        check("R3 no early gap", n_strobe - base, 0);
        wait_strobe(600, got);
        check("R3 gap ends word", {31'd0, got}, 32'd1);
        repeat (300) @(negedge clk);
        check("R3 pause did not split", n_strobe - base, 1);
        check("R3 joined word", word_data, 32'h5A5A_3C3C);
        check("R6 err cleared by valid word", {31'd0, word_err}, 32'd0);

        // R9 test inputs carry a word
        send_word(32'h1357_9BDF, 32, 1'b1);
        wait_strobe(600, got);
        check("R9 test word", word_data, 32'h1357_9BDF);
        check("R9 test word err", {31'd0, word_err}, 32'd0);

        // R9 both test high: null, line activity ignored
        @(negedge clk); test_pos = 1'b1; test_neg = 1'b1;
        repeat (300) @(negedge clk);
        base = n_strobe;
        send_word(32'hFFFF_0000, 32, 1'b0);
        repeat (400) @(negedge clk);
        check("R9 lines ignored under test", n_strobe - base, 0);
        check("R9 data untouched", word_data, 32'h1357_9BDF);
        @(negedge clk); test_pos = 1'b0; test_neg = 1'b0;
        repeat (300) @(negedge clk);
        send_word(32'h0246_8ACE, 32, 1'b0);
        wait_strobe(600, got);
        check("R9 next word clean", word_data, 32'h0246_8ACE);
        check("R9 no stray bits counted", {31'd0, word_err}, 32'd0);
        check("R4 single-cycle strobes end", n_double, 0);

        summary();
        $finish;
    end
endmodule